// File: doc/BRIEF.md
# Forced DRAM Command Issuer

This block lets a processor push single commands onto a DRAM command bus without going through the normal read and write path. Software programs a control register with a chip-select code, a 3-bit select field and one or more request bits. A second register holds the value that goes onto the address pins during a mode register set. The select field has two uses. For a mode register set it names the target register (0 = MR, 1 = EMR, 2 = EMR2, 3 = EMR3). For a single-bank precharge it names the bank. In both cases its value is placed on the bank-address pins.

With a request pending, the block raises a bus request towards the main controller and waits for a grant. It then drives exactly one command cycle on the selected chip select and clears that request bit itself. Several pending requests are served one per grant, in a fixed order, with idle cycles between them. A request that names a reserved chip-select code is dropped without touching the bus, and this leaves a sticky error flag that software can read.

Top module: `dram_force_cmd`

## Requirements
- R1: While reset is held and after its release, cs_n is all ones, {ras_n,cas_n,we_n} is 111, bus_req is 0, and both registers read as zero.
- R2: Control register (rd/wr address 0) layout: bit0 precharge request, bit1 refresh request, bit2 mode-set request, bit3 precharge-all, bits 5:4 chip-select code, bits 10:8 select field, bit16 error flag. Mode value register: address 1, bits ADDR_W-1:0. A mode-set request issues {ras_n,cas_n,we_n}=000 with ba equal to the select field and addr equal to the mode value.
- R3: A refresh request issues 001. The select field is ignored: ba and addr are driven to zero.
- R4: A precharge request issues 010. With precharge-all clear, ba equals the select field and addr is zero (A10 low). With precharge-all set, addr has only bit 10 high and ba is zero, whatever the select field holds.
- R5: Chip-select code 00 drives only cs_n[0] low and code 01 drives only cs_n[1] low. No other chip select goes active.
- R6: bus_req is high while a request with a valid code is pending and the gap has elapsed. A command appears on the outputs in the cycle after a clock edge at which bus_req and bus_gnt are both high. No command is driven while bus_gnt stays low.
- R7: When several requests are pending together, they are issued in the order precharge, refresh, mode set, one per grant.
- R8: At least GAP_CYCLES idle cycles (default 1) follow every command, and bus_req is low in the cycle that shows a command.
- R9: Each request bit reads back as 0 once its command has been issued.
- R10: A request with chip-select code 10 or 11 issues no command and never raises bus_req. Its bit is cleared and the error flag (bit16) is set. The flag stays set until software writes 1 to bit16 of the control register.
- R11: A command occupies exactly one cycle. Every other cycle is a NOP: all cs_n high, 111 on ras_n/cas_n/we_n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Write address: 0 control, 1 mode value |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | 1 | Read address: 0 control, 1 mode value |
| rd_data | output | DATA_W | Read data (combinational) |
| bus_req | output | 1 | Request for the DRAM command bus |
| bus_gnt | input | 1 | Grant from the main controller |
| cs_n | output | NUM_CS | Chip selects, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | 3 | Bank address |
| addr | output | ADDR_W | Address bus |

## Verification
The embedded properties rely on several conditions:
- Reset is high at the first clock edge.
- A grant only counts while bus_req is high.
- The self-clear property holds only in cycles with no software write to the control register.

The stimulus meets these conditions. It derives bus_gnt from bus_req on the falling edge, gated by an enable. It writes the control register only when no earlier request is still pending. The exception is one deliberate case, in which the grant is withheld while three requests wait together so that the issue order can be observed.

// File: rtl/dfc_pkg.sv
package dfc_pkg;

    localparam int SEL_W     = 3;
    localparam int CS_CODE_W = 2;
    localparam int REQ_N     = 3;

    // request bit indices; lower index wins arbitration
    localparam int REQ_PRE = 0;
    localparam int REQ_REF = 1;
    localparam int REQ_MRS = 2;

    // control register field positions
    localparam int F_REQ_LO = 0;
    localparam int F_ALL    = 3;
    localparam int F_CS_LO  = 4;
    localparam int F_SEL_LO = 8;
    localparam int F_ERR    = 16;

    // A10 distinguishes the two precharge forms
    localparam int AP_BIT = 10;

    typedef enum logic [2:0] {
        CMD_MRS = 3'b000,
        CMD_REF = 3'b001,
        CMD_PRE = 3'b010,
        CMD_NOP = 3'b111
    } dram_cmd_e;

    typedef struct packed {
        logic [REQ_N-1:0]     req;
        logic                 pre_all;
        logic [CS_CODE_W-1:0] cs_code;
        logic [SEL_W-1:0]     sel;
        logic                 err;
    } ctrl_t;

    function automatic logic [REQ_N-1:0] pick_first(input logic [REQ_N-1:0] v);
        return v & (~v + REQ_N'(1));
    endfunction

    function automatic dram_cmd_e cmd_of(input logic [REQ_N-1:0] onehot);
        dram_cmd_e c;
        c = CMD_NOP;
        if (onehot[REQ_PRE])      c = CMD_PRE;
        else if (onehot[REQ_REF]) c = CMD_REF;
        else if (onehot[REQ_MRS]) c = CMD_MRS;
        return c;
    endfunction

endpackage

// File: rtl/dfc_ctrl_regs.sv
module dfc_ctrl_regs
    import dfc_pkg::*;
#(
    parameter int ADDR_W = 14,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic [REQ_N-1:0]  hw_clr,
    input  logic              err_set,
    output ctrl_t             ctrl,
    output logic [ADDR_W-1:0] mode_val
);

    ctrl_t             ctrl_q;
    logic [ADDR_W-1:0] mode_q;
    logic              wr_ctrl;
    logic              wr_mode;
    logic [REQ_N-1:0]  sw_set;
    logic              err_clr;
    logic              unused_wr_bits;

    assign wr_ctrl = wr_en && (wr_addr == 1'b0);
    assign wr_mode = wr_en && (wr_addr == 1'b1);
    assign sw_set  = wr_ctrl ? wr_data[F_REQ_LO +: REQ_N] : '0;
    assign err_clr = wr_ctrl && wr_data[F_ERR];
    assign unused_wr_bits = ^{wr_data[DATA_W-1:F_ERR+1], wr_data[15:11], wr_data[7:6]};

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            mode_q <= '0;
        end else begin
            // a fresh software request wins over a same-cycle hardware clear
            ctrl_q.req <= (ctrl_q.req & ~hw_clr) | sw_set;
            if (wr_ctrl) begin
                ctrl_q.pre_all <= wr_data[F_ALL];
                ctrl_q.cs_code <= wr_data[F_CS_LO +: CS_CODE_W];
                ctrl_q.sel     <= wr_data[F_SEL_LO +: SEL_W];
            end
            if (err_set)      ctrl_q.err <= 1'b1;
            else if (err_clr) ctrl_q.err <= 1'b0;
            if (wr_mode) mode_q <= wr_data[ADDR_W-1:0];
        end
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == 1'b0) begin
            rd_data[F_REQ_LO +: REQ_N]    = ctrl_q.req;
            rd_data[F_ALL]                = ctrl_q.pre_all;
            rd_data[F_CS_LO +: CS_CODE_W] = ctrl_q.cs_code;
            rd_data[F_SEL_LO +: SEL_W]    = ctrl_q.sel;
            rd_data[F_ERR]                = ctrl_q.err;
        end else begin
            rd_data[ADDR_W-1:0] = mode_q;
        end
    end

    assign ctrl     = ctrl_q;
    assign mode_val = mode_q;

    // R10: the error flag only falls on an explicit software clear
    assert_err_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.err && !err_clr) |=> ctrl_q.err)
        else $error("error flag dropped without a clear write");

    // R9: a request bit served by hardware is gone on the next cycle
    assert_self_clear_R9: assert property (@(posedge clk) disable iff (rst)
        ((|hw_clr) && !wr_ctrl) |=> ((ctrl_q.req & $past(hw_clr)) == '0))
        else $error("served request bit still set");

endmodule

// File: rtl/dfc_arbiter.sv
module dfc_arbiter
    import dfc_pkg::*;
#(
    parameter int NUM_CS     = 2,
    parameter int GAP_CYCLES = 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [REQ_N-1:0]     req,
    input  logic [CS_CODE_W-1:0] cs_code,
    input  logic                 bus_gnt,
    output logic                 bus_req,
    output logic                 fire,
    output logic [REQ_N-1:0]     pick,
    output logic [REQ_N-1:0]     hw_clr,
    output logic                 err_set
);

    localparam int GAP_W = (GAP_CYCLES < 1) ? 1 : $clog2(GAP_CYCLES + 1);

    logic [GAP_W-1:0] gap_cnt;
    logic             any_req;
    logic             reserved;
    logic             idle;

    assign pick     = pick_first(req);
    assign any_req  = |req;
    assign reserved = int'(cs_code) >= NUM_CS;
    assign idle     = (gap_cnt == '0);
    assign bus_req  = any_req && idle && !reserved;
    assign fire     = bus_req && bus_gnt;
    assign err_set  = any_req && idle && reserved;
    assign hw_clr   = (fire || err_set) ? pick : '0;

    always_ff @(posedge clk) begin
        if (rst)               gap_cnt <= '0;
        else if (fire)         gap_cnt <= GAP_W'(GAP_CYCLES);
        else if (gap_cnt != 0) gap_cnt <= gap_cnt - GAP_W'(1);
    end

    // R8: the cycle after a grant is never a new request
    assert_gap_after_fire_R8: assert property (@(posedge clk) disable iff (rst)
        fire |=> !bus_req)
        else $error("bus requested again without a gap");

    // R7: a grant always serves exactly one request
    assert_one_per_grant_R7: assert property (@(posedge clk) disable iff (rst)
        fire |-> $onehot(hw_clr))
        else $error("grant did not serve exactly one request");

endmodule

// File: rtl/dfc_cmd_encoder.sv
module dfc_cmd_encoder
    import dfc_pkg::*;
#(
    parameter int NUM_CS = 2,
    parameter int ADDR_W = 14
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 fire,
    input  logic [REQ_N-1:0]     pick,
    input  logic [CS_CODE_W-1:0] cs_code,
    input  logic [SEL_W-1:0]     sel,
    input  logic                 pre_all,
    input  logic [ADDR_W-1:0]    mode_val,
    output logic [NUM_CS-1:0]    cs_n,
    output logic                 ras_n,
    output logic                 cas_n,
    output logic                 we_n,
    output logic [SEL_W-1:0]     ba,
    output logic [ADDR_W-1:0]    addr
);

    dram_cmd_e         kind;
    dram_cmd_e         cmd_d, cmd_q;
    logic [SEL_W-1:0]  ba_d;
    logic [ADDR_W-1:0] a_d;
    logic [NUM_CS-1:0] cs_d;

    always_comb begin
        kind = cmd_of(pick);
        ba_d = '0;
        a_d  = '0;
        case (kind)
            CMD_MRS: begin
                ba_d = sel;
                a_d  = mode_val;
            end
            CMD_PRE: begin
                if (pre_all) a_d[AP_BIT] = 1'b1;
                else         ba_d = sel;
            end
            default: ;
        endcase
        cmd_d = fire ? kind : CMD_NOP;
        if (!fire) begin
            ba_d = '0;
            a_d  = '0;
        end
    end

    for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
        assign cs_d[g] = !(fire && (int'(cs_code) == g));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q <= CMD_NOP;
            cs_n  <= '1;
            ba    <= '0;
            addr  <= '0;
        end else begin
            cmd_q <= cmd_d;
            cs_n  <= cs_d;
            ba    <= ba_d;
            addr  <= a_d;
        end
    end

    assign {ras_n, cas_n, we_n} = cmd_q;

    // R5: never more than one chip select active
    assert_onehot_cs_R5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~cs_n))
        else $error("several chip selects active");

    // R11: a deselected bus carries a NOP
    assert_nop_deselected_R11: assert property (@(posedge clk) disable iff (rst)
        (&cs_n) |-> ({ras_n, cas_n, we_n} == 3'b111))
        else $error("strobes active while deselected");

    // R11: a command lasts one cycle
    assert_single_cycle_R11: assert property (@(posedge clk) disable iff (rst)
        !(&cs_n) |=> (&cs_n))
        else $error("command held beyond one cycle");

endmodule

// File: rtl/dram_force_cmd.sv
module dram_force_cmd
    import dfc_pkg::*;
#(
    parameter int NUM_CS     = 2,
    parameter int ADDR_W     = 14,
    parameter int DATA_W     = 32,
    parameter int GAP_CYCLES = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic [NUM_CS-1:0] cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [SEL_W-1:0]  ba,
    output logic [ADDR_W-1:0] addr
);

    ctrl_t             ctrl;
    logic [ADDR_W-1:0] mode_val;
    logic [REQ_N-1:0]  hw_clr;
    logic [REQ_N-1:0]  pick;
    logic              err_set;
    logic              fire;

    dfc_ctrl_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .hw_clr(hw_clr), .err_set(err_set),
        .ctrl(ctrl), .mode_val(mode_val)
    );

    dfc_arbiter #(.NUM_CS(NUM_CS), .GAP_CYCLES(GAP_CYCLES)) u_arb (
        .clk(clk), .rst(rst),
        .req(ctrl.req), .cs_code(ctrl.cs_code), .bus_gnt(bus_gnt),
        .bus_req(bus_req), .fire(fire), .pick(pick),
        .hw_clr(hw_clr), .err_set(err_set)
    );

    dfc_cmd_encoder #(.NUM_CS(NUM_CS), .ADDR_W(ADDR_W)) u_enc (
        .clk(clk), .rst(rst),
        .fire(fire), .pick(pick), .cs_code(ctrl.cs_code), .sel(ctrl.sel),
        .pre_all(ctrl.pre_all), .mode_val(mode_val),
        .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .ba(ba), .addr(addr)
    );

endmodule

// File: tb/dram_force_cmd_tb.sv
module dram_force_cmd_tb;

    localparam int NUM_CS = 2;
    localparam int ADDR_W = 14;
    localparam int DATA_W = 32;

    logic              clk, rst;
    logic              wr_en, wr_addr, rd_addr;
    logic [DATA_W-1:0] wr_data, rd_data;
    logic              bus_req, bus_gnt;
    logic [NUM_CS-1:0] cs_n;
    logic              ras_n, cas_n, we_n;
    logic [2:0]        ba;
    logic [ADDR_W-1:0] addr;

    dram_force_cmd #(.NUM_CS(NUM_CS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .bus_req(bus_req), .bus_gnt(bus_gnt),
        .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr)
    );

    typedef struct packed {
        logic [NUM_CS-1:0] cs_n;
        logic [2:0]        cmd;
        logic [2:0]        ba;
        logic [ADDR_W-1:0] a;
    } exp_t;

    exp_t  sb_q[$];
    string tag_q[$];
    int    n_chk = 0;
    int    n_fail = 0;
    bit    gnt_en = 1'b1;
    bit    done = 1'b0;
    bit    prev_active = 1'b0;

    initial clk = 1'b0;
    always #10 clk = ~clk;

    always @(negedge clk) bus_gnt <= gnt_en && bus_req;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // driver side: kind 0 precharge, 1 refresh, 2 mode set
    task automatic expect_cmd(input int kind, input int cs, input int sel,
                              input bit all, input int mode, input string tag);
        exp_t e;
        e.cs_n = ~(NUM_CS'(1) << cs);
        e.ba   = '0;
        e.a    = '0;
        case (kind)
            0: begin
                e.cmd = 3'b010;
                if (all) e.a[10] = 1'b1;
                else     e.ba = 3'(sel);
            end
            1: e.cmd = 3'b001;
            default: begin
                e.cmd = 3'b000;
                e.ba  = 3'(sel);
                e.a   = ADDR_W'(mode);
            end
        endcase
        sb_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    // monitor side
    always @(negedge clk) begin
        if (!rst) begin : mon
            logic active;
            exp_t got, e;
            string t;
            active = !(&cs_n);
            got = {cs_n, ras_n, cas_n, we_n, ba, addr};
            if (prev_active)
                chk(!active && ({ras_n, cas_n, we_n} == 3'b111), "R8/R11",
                    "cycle after command not NOP", 64'(got), 64'({NUM_CS{1'b1}}));
            if (active) begin
                chk(bus_req == 1'b0, "R8", "bus_req high during command", 64'(bus_req), 64'd0);
                if (sb_q.size() == 0) begin
                    chk(1'b0, "R6", "unexpected command", 64'(got), 64'd0);
                end else begin
                    e = sb_q.pop_front();
                    t = tag_q.pop_front();
                    chk(got == e, t, "command mismatch", 64'(got), 64'(e));
                end
            end
            prev_active = active;
        end
    end

    task automatic wr(input bit a, input logic [DATA_W-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input bit a, output logic [DATA_W-1:0] d);
        @(negedge clk);
        rd_addr = a;
        #1 d = rd_data;
    endtask

    task automatic drain(input string tag);
        for (int i = 0; i < 200 && sb_q.size() != 0; i++) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(sb_q.size() == 0, tag, "commands not issued", 64'(sb_q.size()), 64'd0);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=0 expected=1");
            summary();
            $finish;
        end
    end

    initial begin
        logic [DATA_W-1:0] d;
        bit seen_req;
        rst = 1'b1; wr_en = 1'b0; wr_addr = 1'b0; wr_data = '0; rd_addr = 1'b0;
        repeat (3) @(negedge clk);
        chk(cs_n == '1 && {ras_n, cas_n, we_n} == 3'b111 && bus_req == 1'b0, "R1",
            "reset outputs", 64'({cs_n, ras_n, cas_n, we_n, bus_req}), 64'h3e);
        rst = 1'b0;
        rd(1'b0, d); chk(d == '0, "R1", "control after reset", 64'(d), 64'd0);
        rd(1'b1, d); chk(d == '0, "R1", "mode after reset", 64'(d), 64'd0);

        // R2 R5: mode set on cs0, EMR2
        wr(1'b1, 32'h1234);
        expect_cmd(2, 0, 2, 1'b0, 32'h1234, "R2 R5");
        wr(1'b0, (32'd1 << 2) | (32'd2 << 8));
        drain("R2");
        rd(1'b0, d); chk(d[2:0] == 3'b000, "R9", "mode-set bit cleared", 64'(d[2:0]), 64'd0);

        // R3 R5: refresh on cs1, select field ignored
        expect_cmd(1, 1, 5, 1'b0, 0, "R3 R5");
        wr(1'b0, (32'd1 << 1) | (32'd1 << 4) | (32'd5 << 8));
        drain("R3");

        // R4: single-bank precharge, bank 6 on cs0
        expect_cmd(0, 0, 6, 1'b0, 0, "R4");
        wr(1'b0, 32'd1 | (32'd6 << 8));
        drain("R4");

        // R4: precharge-all on cs1, select field ignored
        expect_cmd(0, 1, 3, 1'b1, 0, "R4");
        wr(1'b0, 32'd1 | (32'd1 << 3) | (32'd1 << 4) | (32'd3 << 8));
        drain("R4");

        // R6 R7: grant withheld, three requests queued together
        gnt_en = 1'b0;
        wr(1'b1, 32'h0abc);
        wr(1'b0, 32'd7 | (32'd1 << 8));
        repeat (20) @(negedge clk);
        chk(bus_req == 1'b1, "R6", "bus_req while pending", 64'(bus_req), 64'd1);
        rd(1'b0, d); chk(d[2:0] == 3'b111, "R6", "requests held without grant", 64'(d[2:0]), 64'd7);
        expect_cmd(0, 0, 1, 1'b0, 0, "R7");
        expect_cmd(1, 0, 1, 1'b0, 0, "R7");
        expect_cmd(2, 0, 1, 1'b0, 32'h0abc, "R7");
        gnt_en = 1'b1;
        drain("R7");
        rd(1'b0, d); chk(d[2:0] == 3'b000, "R9", "all request bits cleared", 64'(d[2:0]), 64'd0);

        // R10: reserved chip-select codes
        seen_req = 1'b0;
        wr(1'b0, (32'd1 << 1) | (32'd2 << 4));
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (bus_req) seen_req = 1'b1;
        end
        chk(!seen_req, "R10", "bus_req with reserved code", 64'(seen_req), 64'd0);
        rd(1'b0, d);
        chk(d[1] == 1'b0 && d[16] == 1'b1, "R10", "dropped bit and error flag",
            64'({d[16], d[1]}), 64'h2);
        wr(1'b0, (32'd1 << 2) | (32'd3 << 4));
        repeat (5) @(negedge clk);
        rd(1'b0, d);
        chk(d[2] == 1'b0 && d[16] == 1'b1, "R10", "error stays sticky", 64'({d[16], d[2]}), 64'h2);
        wr(1'b0, 32'd1 << 16);
        rd(1'b0, d); chk(d[16] == 1'b0, "R10", "error flag cleared", 64'(d[16]), 64'd0);

        // recovery after the error: refresh on cs0
        expect_cmd(1, 0, 0, 1'b0, 0, "R3 R5");
        wr(1'b0, 32'd1 << 1);
        drain("R3");

        done = 1'b1;
        summary();
        $finish;
    end

endmodule